// File: doc/BRIEF.md
# Elitist single-parent evolution strategy sequencer

This block runs a (1+λ) evolution strategy over one chromosome word made of fixed-width gene fields. After a start pulse it loads a 32-bit maximal-length shift register from a seed and uses the register's value as the first, random parent. It then asks an external evaluator to score that parent. Every later generation takes the current best word, makes λ children from it by overwriting randomly chosen genes, and has each child scored in turn. Only one score request is outstanding at any time.

The best word seen so far is always kept. A child whose score equals or beats the held score replaces it, so the search can drift across equal-score solutions and the best solution is never lost. The run ends when a score reaches the target value or when the completed-generation count reaches the programmed cap. The done flag then stays high until the next start. The seed, mutation count, generation cap and target are sampled live and must be held steady during a run. The chromosome width (gene width × gene count) must not exceed 32.

States: IDLE (waits for start, holds done), SEED (copies the shift register into the candidate), ISSUE (one-cycle score request), WAIT (waits for the score strobe), BOUNDARY (promotes the best word to parent and checks the cap), MUTATE (overwrites one gene per cycle). Transitions:
- IDLE→SEED on start.
- SEED→ISSUE.
- ISSUE→WAIT.
- WAIT→IDLE on a target score.
- WAIT→BOUNDARY after the seed score or the last child's score.
- WAIT→MUTATE after any other child.
- BOUNDARY→IDLE when the cap is reached, otherwise BOUNDARY→MUTATE.
- MUTATE→ISSUE when no replacements are left.

Top module: `evo_es_ctrl`

## Requirements
- R1: After reset, done_o, eval_req_o, gen_o, best_o and best_fit_o are all zero.
- R2: Start loads the shift register with seed_i, or with 1 when seed_i is zero. The first candidate is that loaded value. Each step of the register computes next = {r[30:0], r[31]^r[21]^r[1]^r[0]}.
- R3: Each child starts as a copy of its generation's parent and gets mut_count_i gene replacements. For each replacement, the register's bits [2:0] select the gene and bits [6:3] give its new 4-bit value, then the register steps once. Gene g occupies chromosome bits [4g+3:4g].
- R4: eval_req_o is a one-cycle pulse. No new pulse appears until fit_valid_i has answered the previous one, and cand_o holds steady while a request is outstanding.
- R5: Each generation scores exactly λ children (default 5). gen_o increments on the edge that accepts the last child's score, even if that score also ends the run.
- R6: The seed candidate always becomes the best word. After that, a candidate replaces the best word and score when its score is greater than or equal to the held score, so a tie goes to the newer candidate.
- R7: A score of at least target_fit_i ends the run. done_o rises and no further request is issued.
- R8: At each generation boundary, including the one after the seed, a count gen_o ≥ max_gen_i ends the run. With a cap of 0, only the seed is scored.
- R9: done_o stays high until the next start, which clears it and restarts the run. A start while a run is in progress is ignored.
- R10: A fit_valid_i strobe with no request outstanding changes neither the best word nor its score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| seed_i | input | 32 | Shift-register seed |
| mut_count_i | input | MUT_W (4) | Gene replacements per child |
| max_gen_i | input | GEN_W (24) | Generation cap |
| target_fit_i | input | FIT_W (16) | Score that ends the run |
| eval_req_o | output | 1 | Score request pulse |
| cand_o | output | CHROM_W (32) | Candidate word to be scored |
| fit_i | input | FIT_W (16) | Score from the evaluator |
| fit_valid_i | input | 1 | Score strobe |
| best_o | output | CHROM_W (32) | Best word so far |
| best_fit_o | output | FIT_W (16) | Score of best word |
| gen_o | output | GEN_W (24) | Completed generations |
| done_o | output | 1 | Run finished, held until next start |

## Verification
Two functions can fall on the same edge: accepting the last child of a generation, which advances gen_o, and stopping on a target score. The bench forces the target score onto exactly the sixth evaluation, the final child of generation one. It then expects gen_o to read 1 and done_o to rise on that same edge, with no seventh request. A second case aligns a tie with the generation end, using a constant score, and checks that the last child becomes the best word. A behavioural model predicts every candidate word and the held best, score and count, and these are compared on every cycle.

// File: rtl/evo_pkg.sv
package evo_pkg;
    localparam int RNG_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_ISSUE,
        ST_WAIT,
        ST_BOUND,
        ST_MUTATE
    } evo_state_e;

    function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] r);
        return {r[RNG_W-2:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
    endfunction
endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr
    import evo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RNG_W-1:0] seed_i,
    input  logic             step_i,
    output logic [RNG_W-1:0] value_o
);
    logic [RNG_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RNG_W'(1);
        end else if (load_i) begin
            reg_q <= (seed_i == '0) ? RNG_W'(1) : seed_i;
        end else if (step_i) begin
            reg_q <= rng_advance(reg_q);
        end
    end

    assign value_o = reg_q;
endmodule

// File: rtl/evo_gene_mutator.sv
module evo_gene_mutator #(
    parameter int GENE_W    = 4,
    parameter int NUM_GENES = 8,
    parameter int IDX_W     = 3,
    localparam int CHROM_W  = GENE_W * NUM_GENES
) (
    input  logic [CHROM_W-1:0]      chrom_i,
    input  logic [IDX_W+GENE_W-1:0] rnd_i,
    output logic [CHROM_W-1:0]      chrom_o
);
    logic [IDX_W-1:0]  pick;
    logic [GENE_W-1:0] fresh;

    assign pick  = rnd_i[IDX_W-1:0];
    assign fresh = rnd_i[IDX_W +: GENE_W];

    for (genvar g = 0; g < NUM_GENES; g++) begin : g_gene
        assign chrom_o[g*GENE_W +: GENE_W] =
            (pick == IDX_W'(g)) ? fresh : chrom_i[g*GENE_W +: GENE_W];
    end
endmodule

// File: rtl/evo_best_keeper.sv
module evo_best_keeper #(
    parameter int CHROM_W = 32,
    parameter int FIT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               offer_i,
    input  logic               force_i,
    input  logic [CHROM_W-1:0] cand_i,
    input  logic [FIT_W-1:0]   fit_i,
    output logic [CHROM_W-1:0] best_o,
    output logic [FIT_W-1:0]   best_fit_o
);
    logic take;

    assign take = offer_i && (force_i || (fit_i >= best_fit_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_o     <= '0;
            best_fit_o <= '0;
        end else if (take) begin
            best_o     <= cand_i;
            best_fit_o <= fit_i;
        end
    end
endmodule

// File: rtl/evo_es_ctrl.sv
module evo_es_ctrl
    import evo_pkg::*;
#(
    parameter int GENE_W    = 4,
    parameter int NUM_GENES = 8,
    parameter int LAMBDA    = 5,
    parameter int FIT_W     = 16,
    parameter int GEN_W     = 24,
    parameter int MUT_W     = 4,
    localparam int CHROM_W  = GENE_W * NUM_GENES,
    localparam int IDX_W    = (NUM_GENES > 1) ? $clog2(NUM_GENES) : 1,
    localparam int KID_W    = (LAMBDA > 1) ? $clog2(LAMBDA) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RNG_W-1:0]   seed_i,
    input  logic [MUT_W-1:0]   mut_count_i,
    input  logic [GEN_W-1:0]   max_gen_i,
    input  logic [FIT_W-1:0]   target_fit_i,
    output logic               eval_req_o,
    output logic [CHROM_W-1:0] cand_o,
    input  logic [FIT_W-1:0]   fit_i,
    input  logic               fit_valid_i,
    output logic [CHROM_W-1:0] best_o,
    output logic [FIT_W-1:0]   best_fit_o,
    output logic [GEN_W-1:0]   gen_o,
    output logic               done_o
);
    evo_state_e state_q, state_nx;

    logic [CHROM_W-1:0] cand_q, parent_q, mutated;
    logic [KID_W-1:0]   kid_q;
    logic [MUT_W-1:0]   left_q;
    logic [GEN_W-1:0]   gen_q;
    logic               first_q, done_q;
    logic [RNG_W-1:0]   rng;
    logic               rng_load, rng_step, offer;
    logic               perfect, last_kid, cap_hit, scored;

    assign perfect  = fit_i >= target_fit_i;
    assign last_kid = kid_q == KID_W'(LAMBDA - 1);
    assign cap_hit  = gen_q >= max_gen_i;
    assign scored   = (state_q == ST_WAIT) && fit_valid_i;

    evo_lfsr u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rng_load),
        .seed_i  (seed_i),
        .step_i  (rng_step),
        .value_o (rng)
    );

    evo_gene_mutator #(
        .GENE_W    (GENE_W),
        .NUM_GENES (NUM_GENES),
        .IDX_W     (IDX_W)
    ) u_mut (
        .chrom_i (cand_q),
        .rnd_i   (rng[IDX_W+GENE_W-1:0]),
        .chrom_o (mutated)
    );

    evo_best_keeper #(
        .CHROM_W (CHROM_W),
        .FIT_W   (FIT_W)
    ) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .offer_i    (offer),
        .force_i    (first_q),
        .cand_i     (cand_q),
        .fit_i      (fit_i),
        .best_o     (best_o),
        .best_fit_o (best_fit_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nx = ST_SEED;
            ST_SEED:   state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT: begin
                if (fit_valid_i) begin
                    if (perfect)                  state_nx = ST_IDLE;
                    else if (first_q || last_kid) state_nx = ST_BOUND;
                    else                          state_nx = ST_MUTATE;
                end
            end
            ST_BOUND:  state_nx = cap_hit ? ST_IDLE : ST_MUTATE;
            ST_MUTATE: if (left_q == '0) state_nx = ST_ISSUE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        eval_req_o = (state_q == ST_ISSUE);
        rng_load   = (state_q == ST_IDLE) && start_i;
        rng_step   = (state_q == ST_SEED) || ((state_q == ST_MUTATE) && (left_q != '0));
        offer      = scored;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q   <= '0;
            parent_q <= '0;
            kid_q    <= '0;
            left_q   <= '0;
            gen_q    <= '0;
            first_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q  <= 1'b0;
                        gen_q   <= '0;
                        kid_q   <= '0;
                        first_q <= 1'b1;
                    end
                end
                ST_SEED:  cand_q <= CHROM_W'(rng);
                ST_ISSUE: ;
                ST_WAIT: begin
                    if (fit_valid_i) begin
                        first_q <= 1'b0;
                        if (perfect) done_q <= 1'b1;
                        if (!first_q) begin
                            if (last_kid) begin
                                kid_q <= '0;
                                if (gen_q != '1) gen_q <= gen_q + 1'b1;
                            end else begin
                                kid_q  <= kid_q + 1'b1;
                                cand_q <= parent_q;
                                left_q <= mut_count_i;
                            end
                        end
                    end
                end
                ST_BOUND: begin
                    parent_q <= best_o;
                    cand_q   <= best_o;
                    kid_q    <= '0;
                    left_q   <= mut_count_i;
                    if (cap_hit) done_q <= 1'b1;
                end
                ST_MUTATE: begin
                    if (left_q != '0) begin
                        cand_q <= mutated;
                        left_q <= left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cand_o = cand_q;
    assign gen_o  = gen_q;
    assign done_o = done_q;
endmodule

// File: rtl/evo_es_ctrl_chk.sv
module evo_es_ctrl_chk #(
    parameter int CHROM_W = 32,
    parameter int FIT_W   = 16,
    parameter int GEN_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               eval_req_o,
    input logic [CHROM_W-1:0] cand_o,
    input logic [FIT_W-1:0]   fit_i,
    input logic               fit_valid_i,
    input logic [CHROM_W-1:0] best_o,
    input logic [FIT_W-1:0]   best_fit_o,
    input logic [GEN_W-1:0]   gen_o,
    input logic               done_o
);
    logic pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pending <= 1'b0;
        else if (eval_req_o)  pending <= 1'b1;
        else if (fit_valid_i) pending <= 1'b0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !done_o && !eval_req_o);

    a_r4_one_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
        eval_req_o |=> !eval_req_o);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !eval_req_o);

    a_r4_cand_held: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !fit_valid_i |=> $stable(cand_o));

    a_r5_gen_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (gen_o == $past(gen_o)) || (gen_o == $past(gen_o) + 1'b1));

    a_r6_accept_better_or_equal: assert property (@(posedge clk) disable iff (!rst_n)
        pending && fit_valid_i && (fit_i >= best_fit_o)
        |=> (best_fit_o == $past(fit_i)) && (best_o == $past(cand_o)));

    a_r7_silent_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !eval_req_o);

    a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    a_r10_best_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && fit_valid_i) |=> $stable(best_o) && $stable(best_fit_o));
endmodule

bind evo_es_ctrl evo_es_ctrl_chk #(
    .CHROM_W (CHROM_W),
    .FIT_W   (FIT_W),
    .GEN_W   (GEN_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .eval_req_o  (eval_req_o),
    .cand_o      (cand_o),
    .fit_i       (fit_i),
    .fit_valid_i (fit_valid_i),
    .best_o      (best_o),
    .best_fit_o  (best_fit_o),
    .gen_o       (gen_o),
    .done_o      (done_o)
);

// File: tb/evo_es_ctrl_tb_top.sv
module evo_es_ctrl_tb_top;
    localparam int LAM = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic [3:0]  mut_count_i = '0;
    logic [23:0] max_gen_i = '0;
    logic [15:0] target_fit_i = '0;
    logic        eval_req_o;
    logic [31:0] cand_o;
    logic [15:0] fit_i = '0;
    logic        fit_valid_i = 1'b0;
    logic [31:0] best_o;
    logic [15:0] best_fit_o;
    logic [23:0] gen_o;
    logic        done_o;

    always #2 clk = ~clk;

    evo_es_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .seed_i       (seed_i),
        .mut_count_i  (mut_count_i),
        .max_gen_i    (max_gen_i),
        .target_fit_i (target_fit_i),
        .eval_req_o   (eval_req_o),
        .cand_o       (cand_o),
        .fit_i        (fit_i),
        .fit_valid_i  (fit_valid_i),
        .best_o       (best_o),
        .best_fit_o   (best_fit_o),
        .gen_o        (gen_o),
        .done_o       (done_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    // model state
    logic [31:0] m_rng, m_best, m_parent, m_cand;
    int          m_bfit = 0, m_gen = 0, m_kid = 0, m_evals = 0, m_cnt = 0, m_lag = 0;
    bit          m_first = 0, m_out = 0, m_fin = 0, m_run = 0;
    // stimulus knobs
    int          score_mode = 0, score_const = 0, perfect_at = -1, lat = 1;
    bit          start_req = 0, stray_req = 0;
    logic [31:0] goal = 32'hC3A5_9E17;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] rstep(input logic [31:0] r);
        return {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
    endfunction

    function automatic int score(input logic [31:0] c);
        int s = 0;
        if (perfect_at == m_evals - 1) return int'(target_fit_i);
        if (score_mode == 1) return score_const;
        for (int g = 0; g < 8; g++) if (c[g*4 +: 4] == goal[g*4 +: 4]) s++;
        return s;
    endfunction

    task automatic model_start();
        m_rng = (seed_i == 0) ? 32'd1 : seed_i;
        m_first = 1; m_kid = 0; m_gen = 0; m_fin = 0; m_run = 1;
        m_evals = 0; m_lag = 0;
    endtask

    task automatic next_cand(output logic [31:0] c);
        if (m_first) begin
            c = m_rng; m_rng = rstep(m_rng);
        end else begin
            if (m_kid == 0) m_parent = m_best;
            c = m_parent;
            for (int k = 0; k < int'(mut_count_i); k++) begin
                c[int'(m_rng[2:0])*4 +: 4] = m_rng[6:3];
                m_rng = rstep(m_rng);
            end
        end
    endtask

    task automatic on_result(input int f);
        if (m_first || f >= m_bfit) begin m_best = m_cand; m_bfit = f; end
        if (!m_first && m_kid == LAM - 1 && m_gen != 24'hFFFFFF) m_gen++;
        if (f >= int'(target_fit_i)) m_fin = 1;
        else if ((m_first || m_kid == LAM - 1) && m_gen >= int'(max_gen_i)) m_fin = 1;
        if (!m_first) m_kid = (m_kid == LAM - 1) ? 0 : m_kid + 1;
        m_first = 0;
    endtask

    task automatic tick();
        bit just_req = 0;
        logic [31:0] c;
        int f;
        @(negedge clk);
        cyc++;
        chk(best_o == m_best, "R6 best word", best_o, m_best);
        chk(int'(best_fit_o) == m_bfit, "R6 best score", 32'(best_fit_o), 32'(m_bfit));
        chk(int'(gen_o) == m_gen, "R5 generation count", 32'(gen_o), 32'(m_gen));
        if (done_o) begin
            chk(m_fin, "R9 done only after finish", 32'(done_o), 32'(m_fin));
            m_lag = 0;
            m_run = 0;
        end else if (m_fin) begin
            m_lag++;
            chk(m_lag <= 3, "R7 done rises after finish", 32'(done_o), 32'd1);
        end
        if (eval_req_o) begin
            chk(!m_out, "R4 single outstanding request", 32'(m_out), 32'd0);
            chk(!m_fin, "R7 no request after finish", 32'(eval_req_o), 32'd0);
            next_cand(c);
            chk(cand_o == c, m_first ? "R2 seed candidate" : "R3 child candidate", cand_o, c);
            m_cand = c; m_out = 1; m_cnt = lat; m_evals++; just_req = 1;
        end else if (m_out) begin
            chk(cand_o == m_cand, "R4 candidate held", cand_o, m_cand);
        end
        start_i = 0; fit_valid_i = 0;
        if (start_req) begin
            start_i = 1; start_req = 0;
            if (!m_run) model_start();
        end
        if (m_out && !just_req) begin
            m_cnt--;
            if (m_cnt == 0) begin
                f = score(m_cand);
                fit_valid_i = 1; fit_i = 16'(f);
                on_result(f);
                m_out = 0;
            end
        end else if (stray_req && !m_out) begin
            fit_valid_i = 1; fit_i = 16'hFFFF; stray_req = 0;
        end
    endtask

    task automatic run(input logic [31:0] sd, input int mc, input int mg, input int tg,
                       input int mode, input int cst, input int pa, input int lt,
                       input int midstart);
        int n = 0;
        seed_i = sd; mut_count_i = 4'(mc); max_gen_i = 24'(mg); target_fit_i = 16'(tg);
        score_mode = mode; score_const = cst; perfect_at = pa; lat = lt;
        start_req = 1;
        tick();
        while (m_run && n < 20000) begin
            if (n == midstart) start_req = 1;   // R9: ignored while running
            tick();
            n++;
        end
        chk(!m_run, "R7 run completes", 32'(m_run), 32'd0);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_best = '0; m_parent = '0; m_cand = '0; m_rng = 32'd1;
        @(negedge clk); @(negedge clk);
        // R1: reset values
        chk(done_o == 0, "R1 done", 32'(done_o), 0);
        chk(eval_req_o == 0, "R1 request", 32'(eval_req_o), 0);
        chk(gen_o == 0, "R1 generation", 32'(gen_o), 0);
        chk(best_o == 0 && best_fit_o == 0, "R1 best", best_o, 0);
        rst_n = 1'b1;
        tick(); tick();

        // R3 R6: match scoring, two replacements per child, start pulsed mid-run (R9)
        run(32'h1234_ABCD, 2, 40, 8, 0, 0, -1, 1, 7);
        // R9: done held, R10: stray strobe ignored
        for (int i = 0; i < 4; i++) tick();
        stray_req = 1;
        for (int i = 0; i < 3; i++) tick();
        chk(done_o == 1, "R9 done held", 32'(done_o), 1);
        chk(eval_req_o == 0, "R10 no request after stray strobe", 32'(eval_req_o), 0);

        // R2 R6 R8: zero seed, tie scores, cap of 3 -> 1 + 5*3 evaluations
        run(32'h0, 1, 3, 100, 1, 5, -1, 3, -1);
        chk(m_evals == 1 + LAM * 3, "R5 children per generation", 32'(m_evals), 32'(1 + LAM * 3));
        chk(gen_o == 3, "R8 stop at cap", 32'(gen_o), 3);

        // R8: cap of zero scores only the seed
        run(32'hDEAD_BEEF, 1, 0, 100, 1, 2, -1, 2, -1);
        chk(m_evals == 1, "R8 zero cap", 32'(m_evals), 1);

        // R5 R7: perfect score on last child of generation one, same edge as count advance
        run(32'h0BAD_F00D, 3, 9, 10, 1, 3, 5, 1, -1);
        chk(m_evals == 6, "R7 stop on perfect last child", 32'(m_evals), 6);
        chk(gen_o == 1, "R5 count advances with perfect stop", 32'(gen_o), 1);

        // R7: perfect seed
        run(32'h5555_AAAA, 2, 9, 10, 1, 3, 0, 4, -1);
        chk(m_evals == 1, "R7 perfect seed", 32'(m_evals), 1);

        // R3: no replacements -> children equal parent
        run(32'h7777_1111, 0, 2, 100, 1, 1, -1, 1, -1);
        chk(best_o == 32'h7777_1111, "R3 zero mutations keep parent", best_o, 32'h7777_1111);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule